// File: doc/BRIEF.md
# Tuner PLL Divider and Phase Detector Core

This block is the digital heart of a television tuner frequency synthesizer. A reference divider counts crystal clock ticks and produces one pulse every 512, 640 or 1024 ticks. A two-bit step code selects the ratio. A 15-bit programmable main divider counts ticks of the prescaled oscillator signal and produces one pulse every N ticks. A phase-frequency detector compares the two pulse trains. It drives a source control when the main pulse comes first and a sink control when it comes late. When the two pulses coincide, both controls stay idle, which holds the pump in high impedance.

A lock monitor measures how many cycles the pump controls are active in each reference period and derives a lock flag from that count. A shared pin shows this flag in normal use. Test codes route either divider's pulse train to the same pin. Two further control bits are passed to the analog side as registered outputs: the pump current boost and the tuning amplifier enable.

Both count inputs are clock enables in the single `clk` domain. A higher-level wrapper forms them from the crystal and prescaler edges.

Top module: `tuner_pll_core`

## Requirements
- R1: With `ref_tick` high on every cycle, the reference pulse period is selected by the step code: `step_a`=1 with `step_b`=1 gives 512 cycles, `step_a`=0 with `step_b`=1 gives 1024 cycles, and `step_b`=0 gives 640 cycles whatever `step_a` is.
- R2: With `vco_tick` high on every cycle, the main pulse period equals the value of `div_word`. Any value below 1024 is treated as 1024, so the active divide value is never below 1024.
- R3: A change of `div_word` does not alter the count in progress. The new value governs the period that starts at the next main terminal count.
- R4: When the main pulse leads the reference pulse by k cycles, `pump_src` is high for exactly k cycles per period and `pump_snk` stays low.
- R5: When the main pulse lags the reference pulse by k cycles, `pump_snk` is high for exactly k cycles per period and `pump_src` stays low.
- R6: When the main and reference pulses arrive in the same cycle, neither pump control goes high.
- R7: The lock flag leaves reset high. It falls at the first reference pulse whose period held more than LOCK_WIN active pump cycles. It rises again only after LOCK_CYCLES consecutive periods that each held at most LOCK_WIN active pump cycles.
- R8: `ld_pin` follows `tmode` one cycle late. Code 3'b001 shows the main divider pulse, code 3'b010 shows the reference divider pulse, and code 3'b000 or any other code shows the lock flag.
- R9: `tune_en` is the inverse of `amp_off`, and `pump_boost_q` equals `pump_boost`. Each takes effect one cycle after its input.
- R10: While `rst` is high, `pump_src`, `pump_snk`, `tune_en` and `pump_boost_q` are low. `ld_pin` is high when `tmode` is 3'b000.
- R11: `pump_src` and `pump_snk` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Crystal tick enable for the reference divider |
| vco_tick | input | 1 | Prescaled oscillator tick enable for the main divider |
| div_word | input | 15 | Main divide value N |
| step_a | input | 1 | Reference step code, upper bit |
| step_b | input | 1 | Reference step code, lower bit |
| pump_boost | input | 1 | Pump current select; 1 selects the high current |
| amp_off | input | 1 | 1 disables the tuning amplifier |
| tmode | input | 3 | Test pin routing code |
| pump_src | output | 1 | Source current enable |
| pump_snk | output | 1 | Sink current enable |
| pump_boost_q | output | 1 | Registered pump current select |
| tune_en | output | 1 | Registered tuning amplifier enable |
| ld_pin | output | 1 | Lock flag or test pulse output |

## Verification
A wrong divider count or a wrongly decoded step code shows up as a wrong pulse period on `ld_pin` in a test code. A wrongly applied divide word shows up the same way. Each of these is visible within one or two periods, at most about 33,000 cycles. A corrupted detector state shows up within the next reference period, as a pump pulse whose width differs from the injected phase skew or as a pulse on the wrong control. A lock monitor that counts or resets wrongly changes `ld_pin` one or more reference periods too early or too late. Phase skews are applied on both sides of the lock window, so that an off-by-one in the comparison is exposed.

// File: rtl/tuner_pll_pkg.sv
package tuner_pll_pkg;
  typedef enum logic [2:0] {
    TM_LOCK = 3'b000,
    TM_MAIN = 3'b001,
    TM_REF  = 3'b010
  } tmode_e;

  typedef enum logic [1:0] {
    STEP_FINE = 2'b00,
    STEP_MID  = 2'b01,
    STEP_WIDE = 2'b10
  } step_e;

  function automatic step_e step_decode(input logic a, input logic b);
    if (!b)     return STEP_MID;
    else if (a) return STEP_FINE;
    else        return STEP_WIDE;
  endfunction
endpackage

// File: rtl/tpll_ref_div.sv
module tpll_ref_div
  import tuner_pll_pkg::*;
#(
  parameter int R_FINE = 512,
  parameter int R_MID  = 640,
  parameter int R_WIDE = 1024,
  localparam int CW    = $clog2(R_WIDE)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic step_a,
  input  logic step_b,
  output logic pulse
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    unique case (step_decode(step_a, step_b))
      STEP_FINE: last = CW'(R_FINE - 1);
      STEP_MID:  last = CW'(R_MID - 1);
      default:   last = CW'(R_WIDE - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt >= last) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tpll_main_div.sv
module tpll_main_div #(
  parameter int N_W   = 15,
  parameter int N_MIN = 1024
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [N_W-1:0] word,
  output logic           pulse,
  output logic [N_W-1:0] n_act
);
  logic [N_W-1:0] cnt;
  logic [N_W-1:0] word_c;

  assign word_c = (word < N_W'(N_MIN)) ? N_W'(N_MIN) : word;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
      n_act <= word_c;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt >= n_act - 1'b1) begin
          cnt   <= '0;
          pulse <= 1'b1;
          n_act <= word_c;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tpll_pfd.sv
module tpll_pfd (
  input  logic clk,
  input  logic rst,
  input  logic main_p,
  input  logic ref_p,
  output logic src,
  output logic snk
);
  logic src_n, snk_n;

  assign src_n = src | main_p;
  assign snk_n = snk | ref_p;

  always_ff @(posedge clk) begin
    if (rst || (src_n && snk_n)) begin
      src <= 1'b0;
      snk <= 1'b0;
    end else begin
      src <= src_n;
      snk <= snk_n;
    end
  end
endmodule

// File: rtl/tpll_lock.sv
module tpll_lock #(
  parameter int LOCK_WIN    = 4,
  parameter int LOCK_CYCLES = 3,
  localparam int EW = $clog2(LOCK_WIN + 2),
  localparam int GW = $clog2(LOCK_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_p,
  input  logic err,
  output logic locked
);
  logic [EW-1:0] acc;
  logic [EW:0]   tot;
  logic [GW-1:0] good;

  assign tot = {1'b0, acc} + (EW+1)'(err);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      good   <= '0;
      locked <= 1'b1;
    end else if (ref_p) begin
      acc <= '0;
      if (tot > (EW+1)'(LOCK_WIN)) begin
        good   <= '0;
        locked <= 1'b0;
      end else begin
        if (good != GW'(LOCK_CYCLES)) good <= good + 1'b1;
        if (good >= GW'(LOCK_CYCLES - 1)) locked <= 1'b1;
      end
    end else if (err && acc != EW'(LOCK_WIN + 1)) begin
      acc <= acc + 1'b1;
    end
  end
endmodule

// File: rtl/tuner_pll_core.sv
module tuner_pll_core
  import tuner_pll_pkg::*;
#(
  parameter int N_W         = 15,
  parameter int N_MIN       = 1024,
  parameter int R_FINE      = 512,
  parameter int R_MID       = 640,
  parameter int R_WIDE      = 1024,
  parameter int LOCK_WIN    = 4,
  parameter int LOCK_CYCLES = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_tick,
  input  logic           vco_tick,
  input  logic [N_W-1:0] div_word,
  input  logic           step_a,
  input  logic           step_b,
  input  logic           pump_boost,
  input  logic           amp_off,
  input  logic [2:0]     tmode,
  output logic           pump_src,
  output logic           pump_snk,
  output logic           pump_boost_q,
  output logic           tune_en,
  output logic           ld_pin
);
  logic           ref_pulse;
  logic           main_pulse;
  logic           locked;
  logic [N_W-1:0] n_active;
  logic           pin_n;

  tpll_ref_div #(.R_FINE(R_FINE), .R_MID(R_MID), .R_WIDE(R_WIDE)) u_ref (
    .clk(clk), .rst(rst), .tick(ref_tick),
    .step_a(step_a), .step_b(step_b), .pulse(ref_pulse)
  );

  tpll_main_div #(.N_W(N_W), .N_MIN(N_MIN)) u_main (
    .clk(clk), .rst(rst), .tick(vco_tick),
    .word(div_word), .pulse(main_pulse), .n_act(n_active)
  );

  tpll_pfd u_pfd (
    .clk(clk), .rst(rst), .main_p(main_pulse), .ref_p(ref_pulse),
    .src(pump_src), .snk(pump_snk)
  );

  tpll_lock #(.LOCK_WIN(LOCK_WIN), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .ref_p(ref_pulse),
    .err(pump_src | pump_snk), .locked(locked)
  );

  always_comb begin
    unique case (tmode)
      TM_MAIN: pin_n = main_pulse;
      TM_REF:  pin_n = ref_pulse;
      default: pin_n = locked;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_en      <= 1'b0;
      pump_boost_q <= 1'b0;
      ld_pin       <= 1'b1;
    end else begin
      tune_en      <= ~amp_off;
      pump_boost_q <= pump_boost;
      ld_pin       <= pin_n;
    end
  end
endmodule

// File: rtl/tuner_pll_core_chk.sv
module tuner_pll_core_chk #(
  parameter int N_W   = 15,
  parameter int N_MIN = 1024
) (
  input logic           clk,
  input logic           rst,
  input logic           pump_src,
  input logic           pump_snk,
  input logic           main_pulse,
  input logic           ref_pulse,
  input logic           locked,
  input logic [2:0]     tmode,
  input logic           ld_pin,
  input logic           amp_off,
  input logic           tune_en,
  input logic           pump_boost,
  input logic           pump_boost_q,
  input logic [N_W-1:0] n_active
);
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(pump_src && pump_snk));

  p_coincide_r6: assert property (@(posedge clk) disable iff (rst)
    (main_pulse && ref_pulse && !pump_src && !pump_snk) |=> (!pump_src && !pump_snk));

  p_lead_r4: assert property (@(posedge clk) disable iff (rst)
    (main_pulse && !ref_pulse && !pump_snk) |=> pump_src);

  p_lag_r5: assert property (@(posedge clk) disable iff (rst)
    (ref_pulse && !main_pulse && !pump_src) |=> pump_snk);

  p_clamp_r2: assert property (@(posedge clk) disable iff (rst)
    n_active >= N_W'(N_MIN));

  p_pin_lock_r8: assert property (@(posedge clk) disable iff (rst)
    (tmode == 3'b000) |=> (ld_pin == $past(locked)));

  p_tune_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tune_en == !$past(amp_off)) && (pump_boost_q == $past(pump_boost)));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!pump_src && !pump_snk && !tune_en && !pump_boost_q));
endmodule

bind tuner_pll_core tuner_pll_core_chk #(.N_W(N_W), .N_MIN(N_MIN)) chk_i (
  .clk(clk), .rst(rst), .pump_src(pump_src), .pump_snk(pump_snk),
  .main_pulse(main_pulse), .ref_pulse(ref_pulse), .locked(locked),
  .tmode(tmode), .ld_pin(ld_pin), .amp_off(amp_off), .tune_en(tune_en),
  .pump_boost(pump_boost), .pump_boost_q(pump_boost_q), .n_active(n_active)
);

// File: tb/tuner_pll_core_tb_top.sv
`timescale 1ns/1ps
module tuner_pll_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b1;
  logic        vco_tick = 1'b1;
  logic [14:0] div_word = 15'd1024;
  logic        step_a = 1'b0;
  logic        step_b = 1'b1;
  logic        pump_boost = 1'b0;
  logic        amp_off = 1'b1;
  logic [2:0]  tmode = 3'b000;
  logic        pump_src, pump_snk, pump_boost_q, tune_en, ld_pin;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  tuner_pll_core dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .div_word(div_word), .step_a(step_a), .step_b(step_b),
    .pump_boost(pump_boost), .amp_off(amp_off), .tmode(tmode),
    .pump_src(pump_src), .pump_snk(pump_snk), .pump_boost_q(pump_boost_q),
    .tune_en(tune_en), .ld_pin(ld_pin)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog all-R actual=%0d expected<=190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_ref(input bit a, input bit b);
    if (!b) return 640;
    return a ? 512 : 1024;
  endfunction

  function automatic int exp_main(input int w);
    return (w < 1024) ? 1024 : w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pin_pulse();
    @(negedge clk);
    while (ld_pin !== 1'b1) @(negedge clk);
  endtask

  task automatic measure(output int p);
    wait_pin_pulse();
    p = 0;
    do begin
      @(negedge clk);
      p = p + 1;
    end while (ld_pin !== 1'b1);
  endtask

  task automatic count_pump(input int n, output int ups, output int dns);
    ups = 0; dns = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pump_src) ups++;
      if (pump_snk) dns++;
    end
  endtask

  task automatic stall(input bit on_ref, input int k);
    @(negedge clk);
    if (on_ref) ref_tick = 1'b0; else vco_tick = 1'b0;
    repeat (k) @(negedge clk);
    ref_tick = 1'b1;
    vco_tick = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int p, u, d, w, e;
    bit a, b;
    void'($urandom(32'd1234));

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!pump_src && !pump_snk, "R10 pumps idle", {pump_src, pump_snk}, 0);
    chk(!tune_en && !pump_boost_q, "R10 amp off, low current", {tune_en, pump_boost_q}, 0);
    chk(ld_pin == 1'b1, "R10 lock pin high", ld_pin, 1);
    rst = 1'b0;

    // R9: registered control bits, random patterns
    for (int i = 0; i < 8; i++) begin
      amp_off = 1'($urandom);
      pump_boost = 1'($urandom);
      @(negedge clk);
      chk(tune_en == !amp_off, "R9 tune enable", tune_en, !amp_off);
      chk(pump_boost_q == pump_boost, "R9 current select", pump_boost_q, pump_boost);
    end

    // R1: reference ratios, directed then random
    tmode = 3'b010;
    for (int i = 0; i < 6; i++) begin
      if (i < 3) begin
        a = (i == 0); b = (i != 2);
      end else begin
        a = 1'($urandom); b = 1'($urandom);
      end
      step_a = a; step_b = b;
      wait_pin_pulse();
      measure(p);
      e = exp_ref(a, b);
      chk(p == e, "R1 reference period", p, e);
    end

    // R2: main ratio incl. clamp, directed and random
    tmode = 3'b001;
    for (int i = 0; i < 6; i++) begin
      if (i == 0) w = 100;
      else if (i == 1) w = 1024;
      else if (i == 2) w = 1025;
      else w = int'($urandom_range(0, 4000));
      div_word = 15'(w);
      wait_pin_pulse();
      measure(p);
      e = exp_main(w);
      chk(p == e, "R2 main period", p, e);
    end

    // R3: load takes effect at the next terminal count
    div_word = 15'd2000;
    wait_pin_pulse();
    wait_pin_pulse();
    repeat (10) @(negedge clk);
    div_word = 15'd1100;
    p = 10;
    do begin @(negedge clk); p++; end while (ld_pin !== 1'b1);
    chk(p == 2000, "R3 count in progress kept", p, 2000);
    measure(p);
    chk(p == 1100, "R3 new word after terminal", p, 1100);
    // R8: main pulse visible once per period on code 001
    count_pump(0, u, d);
    u = 0;
    for (int i = 0; i < 1100; i++) begin @(negedge clk); if (ld_pin) u++; end
    chk(u == 1, "R8 main pulse routed", u, 1);

    // Phase detector: aligned start
    step_a = 1'b0; step_b = 1'b1; div_word = 15'd1024; tmode = 3'b000;
    do_reset();
    repeat (2048) @(negedge clk);
    count_pump(1024, u, d);
    chk(u == 0 && d == 0, "R6 coincident pulses idle", u + d, 0);
    repeat (4096) @(negedge clk);
    chk(ld_pin == 1'b1, "R7 lock held when aligned", ld_pin, 1);

    // R4: main leads by 6
    stall(1'b1, 6);
    repeat (2048) @(negedge clk);
    count_pump(1024, u, d);
    chk(u == 6, "R4 source width", u, 6);
    chk(d == 0, "R4 sink idle", d, 0);
    chk(ld_pin == 1'b0, "R7 lock drops beyond window", ld_pin, 0);

    // Realign and check consecutive-period requirement
    stall(1'b0, 6);
    repeat (1536) @(negedge clk);
    chk(ld_pin == 1'b0, "R7 not yet relocked", ld_pin, 0);
    repeat (4096) @(negedge clk);
    chk(ld_pin == 1'b1, "R7 relocked", ld_pin, 1);

    // R5: main lags by 2, within window
    stall(1'b0, 2);
    repeat (2048) @(negedge clk);
    count_pump(1024, u, d);
    chk(d == 2, "R5 sink width", d, 2);
    chk(u == 0, "R5 source idle", u, 0);
    chk(ld_pin == 1'b1, "R7 lock kept inside window", ld_pin, 1);

    // R8: other codes show lock flag
    tmode = 3'b011;
    repeat (2) @(negedge clk);
    u = 0;
    for (int i = 0; i < 1100; i++) begin @(negedge clk); if (ld_pin) u++; end
    chk(u == 1100, "R8 code 011 shows lock", u, 1100);
    tmode = 3'b000;

    // R5 and R7: lag grows to 6
    stall(1'b0, 4);
    repeat (2048) @(negedge clk);
    count_pump(1024, u, d);
    chk(d == 6, "R5 sink width large lag", d, 6);
    chk(ld_pin == 1'b0, "R7 lock drops on lag", ld_pin, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule